// File: doc/BRIEF.md
# Page Access Permission Checker with Fault Recording

This block decides whether a memory access may use a page entry that a table walker has already fetched. It takes the kind of access (load, store, instruction fetch), the privilege of the requester, and the three-bit permission field and modified flag of the entry. From these it produces a fault flag and the read, write and execute rights that may be cached for the page. Faults reported by the walker itself (an invalid or malformed entry) enter through a separate input and take precedence over the permission decision.

Every fault is recorded in two registers. The status register holds a code that describes the fault. The address register holds the faulting virtual address. If a second fault arrives before software has read the status, an overflow flag is kept. A read strobe from software clears the status. A no-fault mode lets user accesses continue past permission errors, and write rights are withheld from pages whose modified flag is clear. The first store to such a page therefore goes back to the walker, which can then set the flag.

Top module: `perm_check_unit`

## Requirements
- R1: The access class is the three-bit value {store, fetch, supervisor}. For every class and every permission value 0..7, the permission fault type follows the fixed rule table: 0 = allowed, 2 = protection error, 3 = privilege error. This type is reported in status bits [4:2], and the class is reported in status bits [7:5].
- R2: A user access to an entry with permission 6 or 7 is a privilege error (type 3) whatever the kind of access. A supervisor access to the same entry is checked against its rights in the normal way.
- R3: When no-fault mode is set, a permission error on a user access raises no fault and leaves both registers unchanged. A supervisor permission error is still a fault. A walker-reported error is always a fault.
- R4: When a check raises no fault, the read/write/execute outputs carry the rights of the permission value for the requester's privilege. Supervisor rights for 0..7 are R, RW, RX, RWX, X, RW, RX, RWX. User rights are R, RW, RX, RWX, X, R, none, none. When a check raises a fault, all three rights are 0.
- R5: When the entry's modified flag is 0, the write right is 0 even if the permission value grants writing.
- R6: A fault sets bit 1 of the status register (address valid) on the next clock edge. It also writes the class, the fault type and the entry level; the level goes in bits [9:8]. With no fault and no read, the status register holds its value. After reset the status and address registers are 0.
- R7: If the status register is non-zero and is not being read when a fault arrives, bit 0 (overflow) is set on the next edge. Otherwise bit 0 is 0.
- R8: Every fault loads the full virtual address into the address register on the next clock edge.
- R9: A software read strobe returns the current register values and clears the status register on the next edge. If a fault arrives in the same cycle as the read, the status takes the new fault's value with overflow clear.
- R10: A walker-reported error overrides the permission check. Its 3-bit code is used as the fault type, and the rights are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | A check request is present this cycle |
| acc_write | input | 1 | Access is a store |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is made with supervisor privilege |
| nofault_mode | input | 1 | Suppress user permission faults |
| pte_perm | input | 3 | Permission field of the page entry |
| pte_modified | input | 1 | Modified flag of the page entry |
| walk_err | input | 1 | Walker found an unusable entry |
| walk_code | input | 3 | Fault type for a walker error |
| pte_level | input | LVL_W | Table level of the entry or of the failing step |
| fault_va | input | VA_W | Virtual address of the access |
| sw_rd | input | 1 | Software read strobe, clears status |
| fault_o | output | 1 | The checked access faults |
| rd_ok_o | output | 1 | Read right |
| wr_ok_o | output | 1 | Write right |
| ex_ok_o | output | 1 | Execute right |
| fstat_o | output | LVL_W+8 | Fault status register |
| faddr_o | output | VA_W | Fault address register |

## Verification
The fault flag and the three rights are combinational and are due in the same cycle as the request. The bench drives each request on a falling edge and compares these outputs one time unit later, before any clock edge. The status and address registers are due one rising edge after the request, and the bench compares them at the next falling edge against its own model of the accumulated status. The bench's model uses literal tables for the fault types and the rights, separate from the rule the design computes. Same-cycle read-and-fault collisions and no-fault suppression are driven as explicit cases.

// File: rtl/perm_check_pkg.sv
package perm_check_pkg;

  localparam logic [2:0] FT_NONE = 3'd0;
  localparam logic [2:0] FT_PROT = 3'd2;
  localparam logic [2:0] FT_PRIV = 3'd3;

  // rights as {read, write, execute}
  function automatic logic [2:0] page_rights(input logic user, input logic [2:0] perm);
    logic [2:0] r;
    case (perm)
      3'd0: r = 3'b100;
      3'd1: r = 3'b110;
      3'd2: r = 3'b101;
      3'd3: r = 3'b111;
      3'd4: r = 3'b001;
      3'd5: r = user ? 3'b100 : 3'b110;
      3'd6: r = user ? 3'b000 : 3'b101;
      default: r = user ? 3'b000 : 3'b111;
    endcase
    return r;
  endfunction

  // class = {store, fetch, supervisor}
  function automatic logic [2:0] perm_fault_type(input logic [2:0] cls, input logic [2:0] perm);
    logic       user;
    logic [2:0] need;
    logic [2:0] have;
    user = ~cls[0];
    need = {~cls[2] & ~cls[1], cls[2], cls[1]};
    have = page_rights(user, perm);
    if (user && (perm[2:1] == 2'b11)) return FT_PRIV;
    if ((need & ~have) != 3'b000) return FT_PROT;
    return FT_NONE;
  endfunction

endpackage

// File: rtl/perm_eval.sv
module perm_eval
  import perm_check_pkg::*;
(
  input  logic       chk_valid,
  input  logic       acc_write,
  input  logic       acc_fetch,
  input  logic       acc_super,
  input  logic       nofault_mode,
  input  logic [2:0] pte_perm,
  input  logic       pte_modified,
  input  logic       walk_err,
  input  logic [2:0] walk_code,
  output logic       fault,
  output logic       perm_err,
  output logic [2:0] cls,
  output logic [2:0] ftype,
  output logic [2:0] rights
);
  logic [2:0] p_type;
  logic [2:0] grant;
  logic       suppress;

  always_comb begin
    cls      = {acc_write, acc_fetch, acc_super};
    p_type   = perm_fault_type(cls, pte_perm);
    grant    = page_rights(~acc_super, pte_perm);
    perm_err = chk_valid && !walk_err && (p_type != FT_NONE);
    suppress = perm_err && nofault_mode && !acc_super;
    fault    = chk_valid && (walk_err || (perm_err && !suppress));
    ftype    = walk_err ? walk_code : p_type;
    rights   = fault ? 3'b000 : {grant[2], grant[1] & pte_modified, grant[0]};
  end
endmodule

// File: rtl/fault_regs.sv
module fault_regs #(
  parameter int VA_W  = 32,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_ev,
  input  logic [2:0]       cls,
  input  logic [2:0]       ftype,
  input  logic [LVL_W-1:0] level,
  input  logic [VA_W-1:0]  va,
  input  logic             sw_rd,
  output logic [LVL_W+7:0] status,
  output logic [VA_W-1:0]  addr
);
  localparam int FS_W = LVL_W + 8;

  function automatic logic [FS_W-1:0] status_word(input logic ovf, input logic [2:0] c,
                                                  input logic [2:0] t, input logic [LVL_W-1:0] l);
    return {l, c, t, 1'b1, ovf};
  endfunction

  logic ovf_next;
  assign ovf_next = (status != '0) && !sw_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      addr   <= '0;
    end else if (fault_ev) begin
      status <= status_word(ovf_next, cls, ftype, level);
      addr   <= va;
    end else if (sw_rd) begin
      status <= '0;
    end
  end
endmodule

// File: rtl/perm_check_unit.sv
module perm_check_unit #(
  parameter int VA_W  = 32,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_valid,
  input  logic             acc_write,
  input  logic             acc_fetch,
  input  logic             acc_super,
  input  logic             nofault_mode,
  input  logic [2:0]       pte_perm,
  input  logic             pte_modified,
  input  logic             walk_err,
  input  logic [2:0]       walk_code,
  input  logic [LVL_W-1:0] pte_level,
  input  logic [VA_W-1:0]  fault_va,
  input  logic             sw_rd,
  output logic             fault_o,
  output logic             rd_ok_o,
  output logic             wr_ok_o,
  output logic             ex_ok_o,
  output logic [LVL_W+7:0] fstat_o,
  output logic [VA_W-1:0]  faddr_o
);
  logic       fault_w;
  logic       perm_err_w;
  logic [2:0] cls_w;
  logic [2:0] ftype_w;
  logic [2:0] rights_w;

  perm_eval u_eval (
    .chk_valid    (chk_valid),
    .acc_write    (acc_write),
    .acc_fetch    (acc_fetch),
    .acc_super    (acc_super),
    .nofault_mode (nofault_mode),
    .pte_perm     (pte_perm),
    .pte_modified (pte_modified),
    .walk_err     (walk_err),
    .walk_code    (walk_code),
    .fault        (fault_w),
    .perm_err     (perm_err_w),
    .cls          (cls_w),
    .ftype        (ftype_w),
    .rights       (rights_w)
  );

  fault_regs #(.VA_W(VA_W), .LVL_W(LVL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_ev (fault_w),
    .cls      (cls_w),
    .ftype    (ftype_w),
    .level    (pte_level),
    .va       (fault_va),
    .sw_rd    (sw_rd),
    .status   (fstat_o),
    .addr     (faddr_o)
  );

  assign fault_o = fault_w;
  assign rd_ok_o = rights_w[2];
  assign wr_ok_o = rights_w[1];
  assign ex_ok_o = rights_w[0];
endmodule

// File: rtl/perm_check_sva.sv
module perm_check_sva #(
  parameter int VA_W  = 32,
  parameter int LVL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chk_valid,
  input logic             acc_super,
  input logic             nofault_mode,
  input logic             pte_modified,
  input logic             walk_err,
  input logic             sw_rd,
  input logic             perm_err_w,
  input logic             fault_o,
  input logic             rd_ok_o,
  input logic             wr_ok_o,
  input logic             ex_ok_o,
  input logic [VA_W-1:0]  fault_va,
  input logic [LVL_W+7:0] fstat_o,
  input logic [VA_W-1:0]  faddr_o
);
  AST_SUPPRESS_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && nofault_mode && !acc_super && !walk_err) |-> !fault_o); // R3
  AST_SUPER_NOT_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_err_w && acc_super) |-> fault_o); // R3
  AST_WALK_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && walk_err) |-> fault_o); // R10
  AST_NO_RIGHTS_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !(rd_ok_o || wr_ok_o || ex_ok_o)); // R4
  AST_NO_WRITE_UNMODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !pte_modified) |-> !wr_ok_o); // R5
  AST_VALID_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fstat_o[1]); // R6
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_o && !sw_rd) |=> $stable(fstat_o)); // R6
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !sw_rd && (fstat_o != '0)) |=> fstat_o[0]); // R7
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> (faddr_o == $past(fault_va))); // R8
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && !fault_o) |=> (fstat_o == '0)); // R9
  AST_READ_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && fault_o) |=> !fstat_o[0]); // R9
endmodule

bind perm_check_unit perm_check_sva #(.VA_W(VA_W), .LVL_W(LVL_W)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .chk_valid    (chk_valid),
  .acc_super    (acc_super),
  .nofault_mode (nofault_mode),
  .pte_modified (pte_modified),
  .walk_err     (walk_err),
  .sw_rd        (sw_rd),
  .perm_err_w   (perm_err_w),
  .fault_o      (fault_o),
  .rd_ok_o      (rd_ok_o),
  .wr_ok_o      (wr_ok_o),
  .ex_ok_o      (ex_ok_o),
  .fault_va     (fault_va),
  .fstat_o      (fstat_o),
  .faddr_o      (faddr_o)
);

// File: tb/perm_check_unit_tb.sv
module perm_check_unit_tb;
  localparam int VA_W   = 32;
  localparam int LVL_W  = 2;
  localparam int PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             chk_valid = 1'b0;
  logic             acc_write = 1'b0;
  logic             acc_fetch = 1'b0;
  logic             acc_super = 1'b0;
  logic             nofault_mode = 1'b0;
  logic [2:0]       pte_perm = 3'd0;
  logic             pte_modified = 1'b0;
  logic             walk_err = 1'b0;
  logic [2:0]       walk_code = 3'd0;
  logic [LVL_W-1:0] pte_level = '0;
  logic [VA_W-1:0]  fault_va = '0;
  logic             sw_rd = 1'b0;
  logic             fault_o, rd_ok_o, wr_ok_o, ex_ok_o;
  logic [LVL_W+7:0] fstat_o;
  logic [VA_W-1:0]  faddr_o;

  perm_check_unit #(.VA_W(VA_W), .LVL_W(LVL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .acc_write(acc_write),
    .acc_fetch(acc_fetch), .acc_super(acc_super), .nofault_mode(nofault_mode),
    .pte_perm(pte_perm), .pte_modified(pte_modified), .walk_err(walk_err),
    .walk_code(walk_code), .pte_level(pte_level), .fault_va(fault_va), .sw_rd(sw_rd),
    .fault_o(fault_o), .rd_ok_o(rd_ok_o), .wr_ok_o(wr_ok_o), .ex_ok_o(ex_ok_o),
    .fstat_o(fstat_o), .faddr_o(faddr_o)
  );

  always #(PERIOD/2) clk = ~clk;

  // rule table, row = {store, fetch, supervisor}, column = permission
  int acc_ref [64] = '{
    0,0,0,0,2,0,3,3,  0,0,0,0,2,0,0,0,  2,2,0,0,0,2,3,3,  2,2,0,0,0,2,0,0,
    2,0,2,0,2,2,3,3,  2,0,2,0,2,0,2,0,  2,2,2,0,2,2,3,3,  2,2,2,0,2,2,2,0 };
  // rights {r,w,x}: index user*8+perm
  logic [2:0] rights_ref [16] = '{
    3'b100,3'b110,3'b101,3'b111,3'b001,3'b110,3'b101,3'b111,
    3'b100,3'b110,3'b101,3'b111,3'b001,3'b100,3'b000,3'b000 };

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [LVL_W+7:0] m_stat = '0;
  logic [VA_W-1:0]  m_addr = '0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // one request; comb outputs checked same cycle, registers after the next edge
  task automatic step(input string req, input bit v, input bit w, input bit f, input bit s,
                      input bit nf, input logic [2:0] p, input bit m, input bit we,
                      input logic [2:0] wc, input logic [LVL_W-1:0] lv,
                      input logic [VA_W-1:0] va, input bit rd);
    int         cls;
    int         typ;
    bit         exp_f;
    logic [2:0] exp_r;
    chk_valid = v; acc_write = w; acc_fetch = f; acc_super = s; nofault_mode = nf;
    pte_perm = p; pte_modified = m; walk_err = we; walk_code = wc; pte_level = lv;
    fault_va = va; sw_rd = rd;
    cls = {w, f, s};
    typ = we ? int'(wc) : acc_ref[cls*8 + p];
    exp_f = v && (we || (typ != 0 && !(nf && !s)));
    exp_r = rights_ref[(s ? 0 : 8) + p];
    exp_r[1] = exp_r[1] & m;
    if (exp_f) exp_r = 3'b000;
    #1;
    if (v) begin
      chk(req, "fault", fault_o, exp_f);
      chk(req, "rights", {rd_ok_o, wr_ok_o, ex_ok_o}, exp_r);
    end
    if (exp_f) begin
      m_stat = {lv, cls[2:0], typ[2:0], 1'b1, ((m_stat != '0) && !rd)};
      m_addr = va;
    end else if (rd) begin
      m_stat = '0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, "status", fstat_o, m_stat);
    chk(req, "address", faddr_o, m_addr);
    chk_valid = 1'b0; sw_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R6", "reset status", fstat_o, 0);
    chk("R6", "reset address", faddr_o, 0);
  endtask

  // R1 R2 R4: every class against every permission value
  task automatic t_sweep();
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 8; p++)
        step("R1", 1, c[2], c[1], c[0], 0, p[2:0], 1, 0, 3'd0, 2'd3, 32'h1000_0000 + c*256 + p, 0);
    step("R9", 0, 0, 0, 0, 0, 3'd0, 0, 0, 3'd0, 2'd0, 32'h0, 1);
    step("R2", 1, 0, 0, 0, 0, 3'd7, 1, 0, 3'd0, 2'd3, 32'hAAAA_0007, 0);
    chk("R2", "user perm7 type", fstat_o[4:2], 3);
    step("R2", 1, 0, 0, 1, 0, 3'd7, 1, 0, 3'd0, 2'd3, 32'hAAAA_0017, 1);
  endtask

  task automatic t_modified();
    step("R5", 1, 0, 0, 1, 0, 3'd3, 0, 0, 3'd0, 2'd3, 32'h2000, 0);
    step("R5", 1, 1, 0, 1, 0, 3'd1, 1, 0, 3'd0, 2'd3, 32'h2004, 0);
    step("R5", 1, 0, 0, 0, 0, 3'd1, 0, 0, 3'd0, 2'd3, 32'h2008, 0);
  endtask

  task automatic t_nofault();
    step("R3", 1, 0, 0, 0, 1, 3'd6, 1, 0, 3'd0, 2'd3, 32'h3000, 0);
    chk("R3", "suppressed status", fstat_o, 0);
    step("R3", 1, 1, 0, 1, 1, 3'd2, 1, 0, 3'd0, 2'd3, 32'h3004, 0);
    step("R3", 0, 0, 0, 0, 0, 3'd0, 0, 0, 3'd0, 2'd0, 32'h0, 1);
  endtask

  task automatic t_walk();
    step("R10", 1, 0, 0, 0, 1, 3'd3, 1, 1, 3'd1, 2'd2, 32'hDEAD_BEEF, 0);
    chk("R10", "walk type", fstat_o[4:2], 1);
    chk("R10", "walk level", fstat_o[9:8], 2);
    step("R10", 0, 0, 0, 0, 0, 3'd0, 0, 0, 3'd0, 2'd0, 32'h0, 1);
  endtask

  task automatic t_overflow();
    step("R7", 1, 1, 0, 0, 0, 3'd0, 1, 0, 3'd0, 2'd3, 32'h4000, 0);
    chk("R7", "first fault no overflow", fstat_o[0], 0);
    step("R7", 1, 0, 1, 0, 0, 3'd0, 1, 0, 3'd0, 2'd1, 32'h4444, 0);
    chk("R7", "second fault overflow", fstat_o[0], 1);
    chk("R8", "second address", faddr_o, 32'h4444);
    step("R6", 0, 1, 0, 0, 0, 3'd0, 1, 0, 3'd0, 2'd3, 32'h9999, 0);
  endtask

  task automatic t_read();
    step("R9", 0, 0, 0, 0, 0, 3'd0, 0, 0, 3'd0, 2'd0, 32'h0, 1);
    chk("R9", "cleared", fstat_o, 0);
    step("R9", 1, 0, 0, 0, 0, 3'd4, 1, 0, 3'd0, 2'd3, 32'h5000, 0);
    step("R9", 1, 1, 0, 1, 0, 3'd2, 1, 0, 3'd0, 2'd3, 32'h5004, 1);
    chk("R9", "collision overflow bit", fstat_o[0], 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_modified();
    t_nofault();
    t_walk();
    t_overflow();
    t_read();
    summary();
  end
endmodule